// File: doc/BRIEF.md
# Multi-Style Host Register Bridge

This block lets an external processor reach a bank of byte-wide internal registers through one of four host bus styles. The styles are separate read and write strobes, a single direction line qualified by chip select, a multiplexed address/data bus with an address-latch strobe, and a serial shift port. Whatever the style, the block turns each host cycle into exactly one access on a simple internal register port. That port has an address, write data, a write pulse, a read pulse and read data. The block also drives a ready signal back to the host, with the polarity that the selected style expects.

Every host pin is first passed through a two-flop synchronizer into the system clock domain. All strobe edges are detected on the synchronized copies. The bus style is chosen by a 2-bit input that is captured while reset is held and ignored after that. The shared data lines are split into an input, an output and an output enable. The enable is raised only while read data is being presented.

Top module: `hostbus_bridge`

## Requirements
- R1: The style code on `mode_i` is captured only while `rst_n` is low: 0 = separate strobes, 1 = direction line, 2 = multiplexed, 3 = serial. Changing `mode_i` after reset has no effect on how cycles are decoded.
- R2: Separate-strobe style. With `cs_n_i` low, `wr_n_i` low writes `data_i` to the register at `addr_i`. With `cs_n_i` low, `rd_n_i` low reads that register, and its value appears on `data_o`.
- R3: Direction-line style. `cs_n_i` low is the strobe. `wr_n_i` low selects a write and high selects a read. `rd_n_i` is ignored.
- R4: Multiplexed style. The register address is `data_i[AW-1:0]`, captured when the synchronized `ale_i` falls. `addr_i` is ignored. Strobes behave as in R2.
- R5: In the separate-strobe and multiplexed styles, `rdy_o` is active high. It is low in the cycle the internal access fires and high once the access is complete.
- R6: In the direction-line style, `rdy_o` is active low. It goes low only after the access has completed and returns high once the strobe is removed.
- R7: `data_oe_o` is high only while read data is presented. It is never high during a write or while idle.
- R8: Serial frame, sampled on rising `sclk_i` edges while `cs_n_i` is low, in this order: a direction bit (1 = read, 0 = write), then AW address bits MSB first, then DW data bits MSB first. A write is issued after the last data bit. A read is issued after the last address bit.
- R9: In a serial read, the n-th active `sclk_i` edge after the last address bit (n = 1..DW) places data bit DW-n on `data_o[0]`. The active edge is the rising edge when `sdo_edge_i` is 1 and the falling edge when it is 0. `data_oe_o` is high during that data phase.
- R10: A falling `cs_n_i` restarts the serial frame. A frame cut short causes no register access.
- R11: Each host cycle produces exactly one single-cycle pulse, on either `reg_we_o` or `reg_re_o` and never both, carrying the host's address and data.
- R12: In the serial style, `rdy_o` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; style is captured while low |
| mode_i | input | 2 | Bus style code |
| cs_n_i | input | 1 | Chip select, active low |
| wr_n_i | input | 1 | Write strobe, or direction line |
| rd_n_i | input | 1 | Read strobe |
| ale_i | input | 1 | Address-latch strobe (multiplexed style) |
| addr_i | input | AW | Host address (separate-strobe and direction-line styles) |
| data_i | input | DW | Host data / multiplexed address in |
| data_o | output | DW | Data driven to host; bit 0 is serial out |
| data_oe_o | output | 1 | Output enable for the data lines |
| rdy_o | output | 1 | Ready / acknowledge to host |
| sclk_i | input | 1 | Serial shift clock |
| sdi_i | input | 1 | Serial data in |
| sdo_edge_i | input | 1 | Serial output edge select, 1 = rising |
| reg_addr_o | output | AW | Internal register address |
| reg_wdata_o | output | DW | Internal write data |
| reg_we_o | output | 1 | Internal write pulse |
| reg_re_o | output | 1 | Internal read pulse |
| reg_rdata_i | input | DW | Internal read data (combinational from the bank) |

## Verification
The bench builds the bridge with its defaults: AW = 7, DW = 8, and two synchronizer stages. With a 7-bit address it can use address 127, so the all-ones address is exercised in both the parallel and serial styles. It also makes the serial frame 16 bits long, which lets both output-edge choices be checked bit by bit across the whole data byte. With two synchronizer stages, the access fires a few cycles after a strobe. That leaves the single-cycle ready dip of the separate-strobe style visible to a bench that polls every cycle.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    MODE_SEP = 2'd0,
    MODE_DIR = 2'd1,
    MODE_MUX = 2'd2,
    MODE_SER = 2'd3
  } hb_mode_e;

  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_ACCESS = 2'd1,
    PS_DONE   = 2'd2
  } hb_pstate_e;

  // level driven on the ready pin for a given style and engine phase
  function automatic logic hb_ready_level(hb_mode_e m, logic in_access, logic in_done);
    case (m)
      MODE_DIR: return ~in_done;
      MODE_SER: return 1'b0;
      default:  return ~in_access;
    endcase
  endfunction

  // serial output advances on the edge picked by the select bit
  function automatic logic hb_out_edge(logic sel_rise, logic rise, logic fall);
    return sel_rise ? rise : fall;
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hb_par_engine.sv
module hb_par_engine
  import hb_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hb_mode_e      mode,
  input  logic          en,
  input  logic          s_cs_n,
  input  logic          s_wr_n,
  input  logic          s_rd_n,
  input  logic          s_ale,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] reg_rdata_i,
  output logic [AW-1:0] p_addr,
  output logic [DW-1:0] p_wdata,
  output logic [DW-1:0] p_rdata,
  output logic          p_we,
  output logic          p_re,
  output logic          p_rdy,
  output logic          p_oe
);
  hb_pstate_e    state;
  logic          is_rd;
  logic          ale_q;
  logic [AW-1:0] ale_addr;

  // strobe decode per style
  logic wr_req, rd_req, go, ale_fall;
  assign wr_req   = en & ~s_cs_n & ~s_wr_n;
  assign rd_req   = en & ~s_cs_n & ((mode == MODE_DIR) ? s_wr_n : ~s_rd_n);
  assign go       = wr_req | rd_req;
  assign ale_fall = ale_q & ~s_ale;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q    <= 1'b0;
      ale_addr <= '0;
    end else begin
      ale_q <= s_ale;
      if (ale_fall && mode == MODE_MUX) ale_addr <= data_i[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PS_IDLE;
      is_rd   <= 1'b0;
      p_addr  <= '0;
      p_wdata <= '0;
      p_rdata <= '0;
    end else begin
      case (state)
        PS_IDLE: if (go) begin
          state   <= PS_ACCESS;
          is_rd   <= ~wr_req;
          p_addr  <= (mode == MODE_MUX) ? ale_addr : addr_i;
          p_wdata <= data_i;
        end
        PS_ACCESS: begin
          if (is_rd) p_rdata <= reg_rdata_i;
          state <= PS_DONE;
        end
        PS_DONE: if (!go) state <= PS_IDLE;
        default: state <= PS_IDLE;
      endcase
    end
  end

  assign p_we  = (state == PS_ACCESS) & ~is_rd;
  assign p_re  = (state == PS_ACCESS) &  is_rd;
  assign p_oe  = (state == PS_DONE)   &  is_rd;
  assign p_rdy = hb_ready_level(mode, state == PS_ACCESS, state == PS_DONE);
endmodule

// File: rtl/hb_ser_engine.sv
module hb_ser_engine
  import hb_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          s_cs_n,
  input  logic          s_sclk,
  input  logic          s_sdi,
  input  logic          s_edge_rise,
  input  logic [DW-1:0] reg_rdata_i,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_wdata,
  output logic          s_we,
  output logic          s_re,
  output logic          s_sdo,
  output logic          s_oe
);
  localparam int HW    = AW + 1;
  localparam int FRAME = HW + DW;
  localparam int CW    = $clog2(FRAME + 1);
  localparam logic [CW-1:0] HW_C    = CW'(HW);
  localparam logic [CW-1:0] LASTH_C = CW'(HW - 1);
  localparam logic [CW-1:0] LASTD_C = CW'(FRAME - 1);
  localparam logic [CW-1:0] FRAME_C = CW'(FRAME);

  logic [CW-1:0] cnt;
  logic [HW-1:0] hdr;
  logic [DW-1:0] wsr, osr;
  logic          sclk_q, cs_prev, hdr_evt, dat_evt;

  logic cs_act, rise, fall, frame_start, shift_in, rw, in_data, out_step;
  assign cs_act      = en & ~s_cs_n;
  assign rise        = s_sclk & ~sclk_q;
  assign fall        = ~s_sclk & sclk_q;
  assign frame_start = cs_act & ~cs_prev;
  assign shift_in    = cs_act & rise & (cnt < FRAME_C);
  assign rw          = hdr[HW-1];
  assign in_data     = cnt >= HW_C;
  assign out_step    = cs_act & rw & in_data & hb_out_edge(s_edge_rise, rise, fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      cs_prev <= 1'b0;
      hdr_evt <= 1'b0;
      dat_evt <= 1'b0;
      cnt     <= '0;
      hdr     <= '0;
      wsr     <= '0;
    end else begin
      sclk_q  <= s_sclk;
      cs_prev <= cs_act;
      hdr_evt <= shift_in & (cnt == LASTH_C);
      dat_evt <= shift_in & (cnt == LASTD_C);
      if (frame_start) begin
        cnt <= '0;
      end else if (shift_in) begin
        cnt <= cnt + 1'b1;
        if (cnt < HW_C) hdr <= {hdr[HW-2:0], s_sdi};
        else            wsr <= {wsr[DW-2:0], s_sdi};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osr   <= '0;
      s_sdo <= 1'b0;
    end else if (s_re) begin
      osr <= reg_rdata_i;
    end else if (out_step) begin
      s_sdo <= osr[DW-1];
      osr   <= {osr[DW-2:0], 1'b0};
    end
  end

  assign s_re    = hdr_evt & rw;
  assign s_we    = dat_evt & ~rw;
  assign s_addr  = hdr[AW-1:0];
  assign s_wdata = wsr;
  assign s_oe    = cs_act & ~frame_start & rw & in_data;
endmodule

// File: rtl/hostbus_bridge.sv
module hostbus_bridge
  import hb_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          cs_n_i,
  input  logic          wr_n_i,
  input  logic          rd_n_i,
  input  logic          ale_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          rdy_o,
  input  logic          sclk_i,
  input  logic          sdi_i,
  input  logic          sdo_edge_i,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o,
  output logic          reg_re_o,
  input  logic [DW-1:0] reg_rdata_i
);
  localparam int NSYNC = 7;

  hb_mode_e mode_q;
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= hb_mode_e'(mode_i);
  end

  logic [NSYNC-1:0] raw, syn;
  assign raw = {cs_n_i, wr_n_i, rd_n_i, ale_i, sclk_i, sdi_i, sdo_edge_i};

  hb_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(7'b1110000)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  logic s_cs_n, s_wr_n, s_rd_n, s_ale, s_sclk, s_sdi, s_edge;
  assign {s_cs_n, s_wr_n, s_rd_n, s_ale, s_sclk, s_sdi, s_edge} = syn;

  logic ser_sel;
  assign ser_sel = (mode_q == MODE_SER);

  logic [AW-1:0] p_addr, s_addr;
  logic [DW-1:0] p_wdata, p_rdata, s_wdata;
  logic          p_we, p_re, p_rdy, p_oe, s_we, s_re, s_sdo, s_oe;

  hb_par_engine #(.AW(AW), .DW(DW)) u_par (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .en(~ser_sel),
    .s_cs_n(s_cs_n), .s_wr_n(s_wr_n), .s_rd_n(s_rd_n), .s_ale(s_ale),
    .addr_i(addr_i), .data_i(data_i), .reg_rdata_i(reg_rdata_i),
    .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
    .p_we(p_we), .p_re(p_re), .p_rdy(p_rdy), .p_oe(p_oe)
  );

  hb_ser_engine #(.AW(AW), .DW(DW)) u_ser (
    .clk(clk), .rst_n(rst_n), .en(ser_sel),
    .s_cs_n(s_cs_n), .s_sclk(s_sclk), .s_sdi(s_sdi), .s_edge_rise(s_edge),
    .reg_rdata_i(reg_rdata_i),
    .s_addr(s_addr), .s_wdata(s_wdata), .s_we(s_we), .s_re(s_re),
    .s_sdo(s_sdo), .s_oe(s_oe)
  );

  assign reg_addr_o  = ser_sel ? s_addr  : p_addr;
  assign reg_wdata_o = ser_sel ? s_wdata : p_wdata;
  assign reg_we_o    = p_we | s_we;
  assign reg_re_o    = p_re | s_re;
  assign data_o      = ser_sel ? {{(DW-1){1'b0}}, s_sdo} : p_rdata;
  assign data_oe_o   = ser_sel ? s_oe : p_oe;
  assign rdy_o       = p_rdy;
endmodule

// File: rtl/hb_checker.sv
module hb_checker
  import hb_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_q,
  input logic       reg_we_o,
  input logic       reg_re_o,
  input logic       rdy_o,
  input logic       data_oe_o
);
  logic par_hi;
  assign par_hi = (mode_q == MODE_SEP) || (mode_q == MODE_MUX);

  assert_style_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));

  assert_one_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we_o && reg_re_o));

  assert_we_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o);

  assert_re_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re_o |=> !reg_re_o);

  assert_no_drive_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> !data_oe_o);

  assert_busy_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_we_o || reg_re_o) && par_hi) |-> !rdy_o);

  assert_ack_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_we_o || reg_re_o) && mode_q == MODE_DIR) |-> rdy_o);

  assert_serial_rdy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SER && $past(mode_q) == MODE_SER) |-> !rdy_o);
endmodule

bind hostbus_bridge hb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q),
  .reg_we_o(reg_we_o), .reg_re_o(reg_re_o),
  .rdy_o(rdy_o), .data_oe_o(data_oe_o)
);

// File: tb/hostbus_bridge_tb.sv
module hostbus_bridge_tb;
  localparam int CLK_NS = 10;
  localparam int H = 8;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic       rst_n = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic       cs_n_i = 1'b1, wr_n_i = 1'b1, rd_n_i = 1'b1, ale_i = 1'b0;
  logic [6:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic [7:0] data_o;
  logic       data_oe_o, rdy_o;
  logic       sclk_i = 1'b0, sdi_i = 1'b0, sdo_edge_i = 1'b0;
  logic [6:0] reg_addr_o;
  logic [7:0] reg_wdata_o, reg_rdata_i;
  logic       reg_we_o, reg_re_o;

  hostbus_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .cs_n_i(cs_n_i), .wr_n_i(wr_n_i), .rd_n_i(rd_n_i), .ale_i(ale_i),
    .addr_i(addr_i), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
    .rdy_o(rdy_o), .sclk_i(sclk_i), .sdi_i(sdi_i), .sdo_edge_i(sdo_edge_i),
    .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
    .reg_we_o(reg_we_o), .reg_re_o(reg_re_o), .reg_rdata_i(reg_rdata_i)
  );

  // register bank model
  logic [7:0] mem [128];
  initial for (int i = 0; i < 128; i++) mem[i] = 8'(i * 7 + 3);
  always @(posedge clk) if (reg_we_o) mem[reg_addr_o] <= reg_wdata_o;
  assign reg_rdata_i = mem[reg_addr_o];

  typedef struct {
    bit         we;
    logic [6:0] addr;
    logic [7:0] data;
    string      req;
  } acc_t;
  acc_t exp_q[$];

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [1:0] cur_mode = 2'd0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: every register strobe is popped against the scoreboard
  always @(negedge clk) begin
    if (rst_n && (reg_we_o || reg_re_o)) begin
      acc_t want;
      if (exp_q.size() == 0) begin
        check(1'b0, "R11", "unexpected access addr", int'(reg_addr_o), 0);
      end else begin
        want = exp_q.pop_front();
        check(reg_we_o == want.we, want.req, "access kind (1=write)", int'(reg_we_o), int'(want.we));
        check(reg_addr_o == want.addr, want.req, "address", int'(reg_addr_o), int'(want.addr));
        if (want.we)
          check(reg_wdata_o == want.data, want.req, "write data", int'(reg_wdata_o), int'(want.data));
      end
    end
  end

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode_i = m; cur_mode = m;
    cs_n_i = 1'b1; wr_n_i = 1'b1; rd_n_i = 1'b1; ale_i = 1'b0; sclk_i = 1'b0; sdi_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic par_access(input bit wr, input logic [6:0] a, input logic [7:0] d, input string req);
    logic [7:0] expd;
    bit saw_busy;
    acc_t it;
    expd = wr ? d : mem[a];
    it.we = wr; it.addr = a; it.data = d; it.req = req;
    exp_q.push_back(it);
    @(negedge clk);
    if (cur_mode == 2'd2) begin
      ale_i = 1'b1; data_i = {1'b0, a}; addr_i = ~a;
      repeat (2) @(negedge clk);
      ale_i = 1'b0;
      repeat (4) @(negedge clk);
    end else begin
      addr_i = a;
    end
    data_i = wr ? d : 8'h3C;
    if (cur_mode == 2'd1) begin
      wr_n_i = ~wr; rd_n_i = 1'b0;   // rd_n_i must be ignored here (R3)
      @(negedge clk);
      cs_n_i = 1'b0;
    end else begin
      cs_n_i = 1'b0;
      if (wr) wr_n_i = 1'b0; else rd_n_i = 1'b0;
    end
    saw_busy = 1'b0;
    repeat (10) begin
      @(negedge clk);
      if (!rdy_o) saw_busy = 1'b1;
    end
    if (cur_mode == 2'd1) begin
      check(rdy_o == 1'b0, "R6", "ack level when done", int'(rdy_o), 0);
    end else begin
      check(saw_busy, "R5", "ready dipped low", int'(saw_busy), 1);
      check(rdy_o == 1'b1, "R5", "ready level when done", int'(rdy_o), 1);
    end
    if (wr) begin
      check(data_oe_o == 1'b0, "R7", "oe during write", int'(data_oe_o), 0);
    end else begin
      check(data_o == expd, req, "read data on bus", int'(data_o), int'(expd));
      check(data_oe_o == 1'b1, "R7", "oe during read", int'(data_oe_o), 1);
    end
    cs_n_i = 1'b1; wr_n_i = 1'b1; rd_n_i = 1'b1;
    repeat (6) @(negedge clk);
    check(rdy_o == 1'b1, (cur_mode == 2'd1) ? "R6" : "R5", "ready idle level", int'(rdy_o), 1);
    check(data_oe_o == 1'b0, "R7", "oe idle", int'(data_oe_o), 0);
  endtask

  task automatic ser_frame(input bit rw, input logic [6:0] a, input logic [7:0] d,
                           input int nb, input string req);
    logic [15:0] bits;
    logic [7:0]  rdv;
    acc_t it;
    bits = {rw, a, d};
    rdv  = mem[a];
    if ((rw && nb >= 8) || (!rw && nb == 16)) begin
      it.we = ~rw; it.addr = a; it.data = d; it.req = req;
      exp_q.push_back(it);
    end
    @(negedge clk);
    cs_n_i = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      sdi_i = bits[15-i];
      repeat (H) @(negedge clk);
      sclk_i = 1'b1;
      repeat (H) @(negedge clk);
      if (rw && sdo_edge_i && i >= 8)
        check(data_o[0] == rdv[15-i], "R9", "serial out bit (rising)", int'(data_o[0]), int'(rdv[15-i]));
      if (i == 8)
        check(data_oe_o == rw, rw ? "R9" : "R7", "oe in data phase", int'(data_oe_o), int'(rw));
      sclk_i = 1'b0;
      repeat (H) @(negedge clk);
      if (rw && !sdo_edge_i && i >= 7 && i < 15)
        check(data_o[0] == rdv[14-i], "R9", "serial out bit (falling)", int'(data_o[0]), int'(rdv[14-i]));
    end
    cs_n_i = 1'b1;
    repeat (6) @(negedge clk);
    check(data_oe_o == 1'b0, "R9", "oe after frame", int'(data_oe_o), 0);
    check(rdy_o == 1'b0, "R12", "serial ready", int'(rdy_o), 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog: actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    // separate-strobe style
    do_reset(2'd0);
    check(rdy_o == 1'b1, "R5", "reset ready", int'(rdy_o), 1);
    check(data_oe_o == 1'b0, "R7", "reset oe", int'(data_oe_o), 0);
    check(reg_we_o == 1'b0 && reg_re_o == 1'b0, "R11", "reset strobes", int'(reg_we_o | reg_re_o), 0);
    mode_i = 2'd3;   // must not change the running style (R1)
    par_access(1'b1, 7'h05, 8'hA5, "R2");
    par_access(1'b0, 7'h05, 8'h00, "R2");
    par_access(1'b1, 7'h7F, 8'hFF, "R1");
    par_access(1'b0, 7'h7F, 8'h00, "R1");
    par_access(1'b1, 7'h00, 8'h00, "R2");
    par_access(1'b0, 7'h11, 8'h00, "R2");

    // direction-line style
    do_reset(2'd1);
    par_access(1'b1, 7'h2A, 8'h3C, "R3");
    par_access(1'b0, 7'h2A, 8'h00, "R3");
    par_access(1'b0, 7'h40, 8'h00, "R3");

    // multiplexed style
    do_reset(2'd2);
    par_access(1'b1, 7'h33, 8'h96, "R4");
    par_access(1'b0, 7'h33, 8'h00, "R4");
    par_access(1'b0, 7'h7F, 8'h00, "R4");

    // serial, output on falling edge
    sdo_edge_i = 1'b0;
    do_reset(2'd3);
    check(rdy_o == 1'b0, "R12", "serial ready after reset", int'(rdy_o), 0);
    ser_frame(1'b0, 7'h12, 8'hC3, 16, "R8");
    ser_frame(1'b1, 7'h12, 8'h00, 16, "R8");
    ser_frame(1'b0, 7'h22, 8'h99, 6,  "R10");
    ser_frame(1'b0, 7'h22, 8'h5A, 16, "R10");
    ser_frame(1'b1, 7'h22, 8'h00, 16, "R10");

    // serial, output on rising edge
    sdo_edge_i = 1'b1;
    do_reset(2'd3);
    ser_frame(1'b1, 7'h7F, 8'h00, 16, "R9");
    ser_frame(1'b1, 7'h05, 8'h00, 16, "R9");

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R11", "accesses left pending", exp_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end
endmodule